// File: doc/BRIEF.md
# Two-Queue Drain Scheduler for a Swappable Inspection Engine

This block sits between two packet queues and one content-inspection engine. The engine can hold only one rule set at a time. Set A serves queue A and set B serves queue B. The scheduler connects exactly one queue to the engine. It empties that queue down to a packet boundary, and only then starts a rule-set swap. A swap is a long dead period that stands in for reloading the engine's logic. During that period every read stops. Writes into both queues carry on, so no packet is dropped.

The swap ends when the loader reports completion or when a parameterised cycle budget runs out, whichever comes first. The loaded set then flips and the other queue is served. A swap counter and a per-queue peak-occupancy register are exposed for monitoring. Each queue also has a sticky overflow flag, raised when its occupancy exceeds a configured depth limit. That limit is sized so a queue can absorb one full outage and then drain, because the read clock is faster than the write clock.

The states are IDLE, SERVE_A, RECONF_TO_B, SERVE_B and RECONF_TO_A. The transitions are:
- IDLE→SERVE_x when the loaded set's queue is non-empty.
- IDLE→RECONF_TO_y when only the other queue is non-empty.
- SERVE_x→IDLE when the served queue is empty at a packet boundary and the other queue is empty.
- SERVE_x→RECONF_TO_y when the served queue is empty at a packet boundary and the other queue holds data.
- RECONF_TO_y→SERVE_y on done or on timer expiry.

Top module: `dual_queue_sched`

## Requirements
- R1: At most one of `a_rd_en`/`b_rd_en` is high in any cycle. A read is issued only from a non-empty queue whose rule set is loaded (`eng_sel` 0 = set A, 1 = set B).
- R2: After reset the scheduler is in IDLE with set A loaded. Both read enables, `reconf_req`, `swap_count`, both peaks and both overflow flags are zero.
- R3: The served queue is read every cycle it is non-empty, until it is empty at a packet boundary. The scheduler then swaps to the other set if the other queue holds data, or returns to IDLE otherwise.
- R4: If the served queue runs empty in the middle of a packet (the last word read did not carry the end marker), the scheduler keeps serving that queue. It issues no swap, even with the other queue waiting, and resumes reading when words arrive.
- R5: While a swap is in progress, `reconf_req` is high, no read is issued and `eng_sel` does not change. Writes into the queues are still absorbed.
- R6: A swap ends at the first edge after `reconf_done` is seen, or after `RECONF_CYCLES` cycles without it. `eng_sel` then flips, `swap_count` increments by one and the new set's queue is served.
- R7: In IDLE with both queues empty, no swap is started. When both queues hold data, the queue of the loaded set is served first.
- R8: Each peak register holds the largest occupancy its queue has reported since reset.
- R9: An overflow flag sets when its queue's occupancy exceeds `DEPTH_LIMIT`, not when it is equal to it, and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_empty | input | 1 | Queue A has no word |
| a_pkt_end | input | 1 | Head word of queue A ends a packet |
| a_level | input | LEVEL_W | Occupancy of queue A |
| b_empty | input | 1 | Queue B has no word |
| b_pkt_end | input | 1 | Head word of queue B ends a packet |
| b_level | input | LEVEL_W | Occupancy of queue B |
| reconf_done | input | 1 | Loader reports the new rule set is in place |
| a_rd_en | output | 1 | Pop one word from queue A |
| b_rd_en | output | 1 | Pop one word from queue B |
| eng_sel | output | 1 | Loaded rule set, 0 = A, 1 = B |
| reconf_req | output | 1 | Swap in progress; loader must run |
| swap_count | output | SWAP_W | Completed swaps, wrapping |
| a_peak | output | LEVEL_W | Peak occupancy of queue A |
| b_peak | output | LEVEL_W | Peak occupancy of queue B |
| a_ovf | output | 1 | Sticky overflow of queue A |
| b_ovf | output | 1 | Sticky overflow of queue B |

## Verification
Draining is tried with whole packets in one queue. This separates a correct return to IDLE from a spurious swap. A half-written packet with the other queue already waiting shows whether the boundary rule really holds off the swap. Swaps are ended both by timer expiry and by an early done, each with an exact count of outage cycles, and writes are injected mid-outage to show they are absorbed while reads stay off. Filling both queues in the same cycle tells loaded-set priority apart from plain alternation. Filling one queue to exactly the limit and the other past it separates the strict comparison from an inclusive one.

// File: rtl/dqs_pkg.sv
package dqs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE        = 3'd0,
        ST_SERVE_A     = 3'd1,
        ST_RECONF_TO_B = 3'd2,
        ST_SERVE_B     = 3'd3,
        ST_RECONF_TO_A = 3'd4
    } sched_state_e;

    typedef enum logic {
        SET_A = 1'b0,
        SET_B = 1'b1
    } rule_set_e;

    localparam int unsigned NUM_QUEUES = 2;

endpackage

// File: rtl/dqs_swap_timer.sv
module dqs_swap_timer #(
    parameter int unsigned CYCLES = 1330000,
    localparam int unsigned CW = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Expires in the CYCLES-th cycle of a run, counting the first as one
    always_comb begin
        expired = run && (cnt == CW'(CYCLES - 1));
    end

endmodule

// File: rtl/dqs_occ_mon.sv
module dqs_occ_mon #(
    parameter int unsigned LEVEL_W     = 25,
    parameter int unsigned DEPTH_LIMIT = 20000000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LEVEL_W-1:0] level,
    output logic [LEVEL_W-1:0] peak,
    output logic               ovf
);

    localparam logic [LEVEL_W-1:0] LIMIT = LEVEL_W'(DEPTH_LIMIT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            peak <= '0;
            ovf  <= 1'b0;
        end else begin
            if (level > peak) begin
                peak <= level;
            end
            if (level > LIMIT) begin
                ovf <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/dqs_fsm.sv
module dqs_fsm
    import dqs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic a_empty,
    input  logic b_empty,
    input  logic a_pkt_end,
    input  logic b_pkt_end,
    input  logic reconf_done,
    input  logic timer_expired,
    output logic a_rd,
    output logic b_rd,
    output logic eng_sel,
    output logic reconf_req,
    output logic timer_run,
    output logic swap_pulse
);

    sched_state_e state, state_nx;
    rule_set_e    loaded, loaded_nx;
    logic         in_pkt, in_pkt_nx;
    logic         own_empty, other_empty, swap_end;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            loaded <= SET_A;
            in_pkt <= 1'b0;
        end else begin
            state  <= state_nx;
            loaded <= loaded_nx;
            in_pkt <= in_pkt_nx;
        end
    end

    // Next-state logic
    always_comb begin
        own_empty   = (loaded == SET_A) ? a_empty : b_empty;
        other_empty = (loaded == SET_A) ? b_empty : a_empty;
        swap_end    = reconf_done || timer_expired;
        state_nx    = state;
        loaded_nx   = loaded;
        unique case (state)
            ST_IDLE: begin
                if (!own_empty) begin
                    state_nx = (loaded == SET_A) ? ST_SERVE_A : ST_SERVE_B;
                end else if (!other_empty) begin
                    state_nx = (loaded == SET_A) ? ST_RECONF_TO_B : ST_RECONF_TO_A;
                end
            end
            ST_SERVE_A: begin
                if (a_empty && !in_pkt) begin
                    state_nx = b_empty ? ST_IDLE : ST_RECONF_TO_B;
                end
            end
            ST_SERVE_B: begin
                if (b_empty && !in_pkt) begin
                    state_nx = a_empty ? ST_IDLE : ST_RECONF_TO_A;
                end
            end
            ST_RECONF_TO_B: begin
                if (swap_end) begin
                    state_nx  = ST_SERVE_B;
                    loaded_nx = SET_B;
                end
            end
            ST_RECONF_TO_A: begin
                if (swap_end) begin
                    state_nx  = ST_SERVE_A;
                    loaded_nx = SET_A;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Output logic
    always_comb begin
        a_rd       = 1'b0;
        b_rd       = 1'b0;
        reconf_req = 1'b0;
        swap_pulse = 1'b0;
        in_pkt_nx  = in_pkt;
        unique case (state)
            ST_SERVE_A: a_rd = !a_empty;
            ST_SERVE_B: b_rd = !b_empty;
            ST_RECONF_TO_B, ST_RECONF_TO_A: begin
                reconf_req = 1'b1;
                swap_pulse = reconf_done || timer_expired;
            end
            default: ;
        endcase
        if (a_rd) begin
            in_pkt_nx = !a_pkt_end;
        end else if (b_rd) begin
            in_pkt_nx = !b_pkt_end;
        end
        timer_run = reconf_req;
        eng_sel   = loaded;
    end

endmodule

// File: rtl/dual_queue_sched.sv
module dual_queue_sched #(
    parameter int unsigned LEVEL_W       = 25,
    parameter int unsigned DEPTH_LIMIT   = 20000000,
    parameter int unsigned RECONF_CYCLES = 1330000,
    parameter int unsigned SWAP_W        = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               a_empty,
    input  logic               a_pkt_end,
    input  logic [LEVEL_W-1:0] a_level,
    input  logic               b_empty,
    input  logic               b_pkt_end,
    input  logic [LEVEL_W-1:0] b_level,
    input  logic               reconf_done,
    output logic               a_rd_en,
    output logic               b_rd_en,
    output logic               eng_sel,
    output logic               reconf_req,
    output logic [SWAP_W-1:0]  swap_count,
    output logic [LEVEL_W-1:0] a_peak,
    output logic [LEVEL_W-1:0] b_peak,
    output logic               a_ovf,
    output logic               b_ovf
);

    import dqs_pkg::*;

    logic timer_run, timer_expired, swap_pulse;
    logic [LEVEL_W-1:0] lvl  [NUM_QUEUES];
    logic [LEVEL_W-1:0] peak [NUM_QUEUES];
    logic               ovf  [NUM_QUEUES];

    dqs_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .a_empty      (a_empty),
        .b_empty      (b_empty),
        .a_pkt_end    (a_pkt_end),
        .b_pkt_end    (b_pkt_end),
        .reconf_done  (reconf_done),
        .timer_expired(timer_expired),
        .a_rd         (a_rd_en),
        .b_rd         (b_rd_en),
        .eng_sel      (eng_sel),
        .reconf_req   (reconf_req),
        .timer_run    (timer_run),
        .swap_pulse   (swap_pulse)
    );

    dqs_swap_timer #(.CYCLES(RECONF_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (timer_run),
        .expired(timer_expired)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swap_count <= '0;
        end else if (swap_pulse) begin
            swap_count <= swap_count + 1'b1;
        end
    end

    assign lvl[0] = a_level;
    assign lvl[1] = b_level;

    for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_mon
        dqs_occ_mon #(
            .LEVEL_W    (LEVEL_W),
            .DEPTH_LIMIT(DEPTH_LIMIT)
        ) u_mon (
            .clk  (clk),
            .rst_n(rst_n),
            .level(lvl[q]),
            .peak (peak[q]),
            .ovf  (ovf[q])
        );
    end

    assign a_peak = peak[0];
    assign b_peak = peak[1];
    assign a_ovf  = ovf[0];
    assign b_ovf  = ovf[1];

endmodule

// File: rtl/dual_queue_sched_chk.sv
module dual_queue_sched_chk #(
    parameter int unsigned SWAP_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              a_empty,
    input logic              b_empty,
    input logic              a_rd_en,
    input logic              b_rd_en,
    input logic              eng_sel,
    input logic              reconf_req,
    input logic [SWAP_W-1:0] swap_count,
    input logic              a_ovf,
    input logic              b_ovf
);

    assert_one_reader_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_rd_en && b_rd_en));

    assert_a_read_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        a_rd_en |-> (!a_empty && !eng_sel));

    assert_b_read_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        b_rd_en |-> (!b_empty && eng_sel));

    assert_no_read_in_swap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reconf_req |-> (!a_rd_en && !b_rd_en));

    assert_set_changes_at_swap_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(eng_sel) |-> $fell(reconf_req));

    assert_swap_counted_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reconf_req) |-> (swap_count == SWAP_W'($past(swap_count) + 1'b1)));

    assert_a_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        a_ovf |=> a_ovf);

    assert_b_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        b_ovf |=> b_ovf);

endmodule

bind dual_queue_sched dual_queue_sched_chk #(.SWAP_W(SWAP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_empty   (a_empty),
    .b_empty   (b_empty),
    .a_rd_en   (a_rd_en),
    .b_rd_en   (b_rd_en),
    .eng_sel   (eng_sel),
    .reconf_req(reconf_req),
    .swap_count(swap_count),
    .a_ovf     (a_ovf),
    .b_ovf     (b_ovf)
);

// File: tb/dual_queue_sched_bench.sv
module dual_queue_sched_bench;

    localparam int LW    = 16;
    localparam int LIMIT = 24;
    localparam int RCYC  = 12;
    localparam int SW    = 8;
    localparam int PKT   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reconf_done = 1'b0;
    logic a_rd_en, b_rd_en, eng_sel, reconf_req, a_ovf, b_ovf;
    logic [SW-1:0] swap_count;
    logic [LW-1:0] a_peak, b_peak;

    // Queue models: word counts and position of the head word in its packet
    int a_cnt = 0, a_pos = 0, b_cnt = 0, b_pos = 0;
    int a_push = 0, b_push = 0;
    logic a_empty, b_empty, a_pkt_end, b_pkt_end;
    logic [LW-1:0] a_level, b_level;

    assign a_empty   = (a_cnt == 0);
    assign b_empty   = (b_cnt == 0);
    assign a_pkt_end = (a_pos == PKT - 1);
    assign b_pkt_end = (b_pos == PKT - 1);
    assign a_level   = LW'(a_cnt);
    assign b_level   = LW'(b_cnt);

    always #2 clk = ~clk;

    dual_queue_sched #(
        .LEVEL_W(LW), .DEPTH_LIMIT(LIMIT), .RECONF_CYCLES(RCYC), .SWAP_W(SW)
    ) u_dual_queue_sched (
        .clk(clk), .rst_n(rst_n),
        .a_empty(a_empty), .a_pkt_end(a_pkt_end), .a_level(a_level),
        .b_empty(b_empty), .b_pkt_end(b_pkt_end), .b_level(b_level),
        .reconf_done(reconf_done),
        .a_rd_en(a_rd_en), .b_rd_en(b_rd_en), .eng_sel(eng_sel),
        .reconf_req(reconf_req), .swap_count(swap_count),
        .a_peak(a_peak), .b_peak(b_peak), .a_ovf(a_ovf), .b_ovf(b_ovf)
    );

    always @(posedge clk) begin
        a_cnt <= a_cnt - (a_rd_en ? 1 : 0) + a_push;
        b_cnt <= b_cnt - (b_rd_en ? 1 : 0) + b_push;
        if (a_rd_en) a_pos <= (a_pos + 1) % PKT;
        if (b_rd_en) b_pos <= (b_pos + 1) % PKT;
    end

    // Observation counters, sampled mid-cycle
    int a_reads = 0, b_reads = 0, rc_cycles = 0, bad_rd = 0, first_rd = 0;
    always @(negedge clk) begin
        if (a_rd_en) a_reads++;
        if (b_rd_en) b_reads++;
        if (reconf_req) rc_cycles++;
        if ((a_rd_en && b_rd_en) || (reconf_req && (a_rd_en || b_rd_en))) bad_rd++;
        if (first_rd == 0 && a_rd_en) first_rd = 1;
        if (first_rd == 0 && b_rd_en) first_rd = 2;
    end

    int n_checks = 0, n_errors = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_obs();
        a_reads = 0; b_reads = 0; rc_cycles = 0; bad_rd = 0; first_rd = 0;
    endtask

    task automatic push(input int na, input int nb);
        @(negedge clk);
        a_push = na;
        b_push = nb;
        @(negedge clk);
        a_push = 0;
        b_push = 0;
    endtask

    task automatic idle_wait(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 rd_en", int'(a_rd_en) + int'(b_rd_en), 0);
        chk("R2 reconf_req", int'(reconf_req), 0);
        chk("R2 eng_sel", int'(eng_sel), 0);
        chk("R2 swap_count", int'(swap_count), 0);
        chk("R2 peaks", int'(a_peak) + int'(b_peak), 0);
        chk("R2 ovf", int'(a_ovf) + int'(b_ovf), 0);
    endtask

    task automatic t_drain_a();
        clear_obs();
        push(8, 0);
        idle_wait(30);
        chk("R3 a_reads", a_reads, 8);
        chk("R1 b_reads", b_reads, 0);
        chk("R7 no swap when both empty", rc_cycles, 0);
        chk("R3 eng_sel", int'(eng_sel), 0);
    endtask

    task automatic t_swap_timer();
        clear_obs();
        push(0, 4);
        idle_wait(30);
        chk("R6 timed outage length", rc_cycles, RCYC);
        chk("R6 b_reads", b_reads, 4);
        chk("R6 eng_sel", int'(eng_sel), 1);
        chk("R6 swap_count", int'(swap_count), 1);
        chk("R5 no read during swap", bad_rd, 0);
    endtask

    task automatic t_swap_done();
        int k = 0;
        clear_obs();
        push(4, 0);
        while (k < 3) begin
            @(negedge clk);
            if (reconf_req) begin
                k++;
                a_push = (k == 1) ? 8 : 0;
            end
        end
        a_push = 0;
        reconf_done = 1'b1;
        @(negedge clk);
        reconf_done = 1'b0;
        idle_wait(30);
        chk("R6 done ends outage early", rc_cycles, 3);
        chk("R5 writes absorbed, a_reads", a_reads, 12);
        chk("R8 a_peak", int'(a_peak), 12);
        chk("R6 eng_sel", int'(eng_sel), 0);
        chk("R6 swap_count", int'(swap_count), 2);
        chk("R5 no read during swap", bad_rd, 0);
    endtask

    task automatic t_no_split();
        clear_obs();
        push(2, 4);
        idle_wait(15);
        chk("R4 partial packet read", a_reads, 2);
        chk("R4 no swap mid-packet", rc_cycles, 0);
        chk("R4 b untouched", b_reads, 0);
        push(2, 0);
        idle_wait(40);
        chk("R4 a_reads after rest", a_reads, 4);
        chk("R3 swap after boundary", rc_cycles, RCYC);
        chk("R3 b_reads", b_reads, 4);
        chk("R6 swap_count", int'(swap_count), 3);
    endtask

    task automatic t_prefer();
        clear_obs();
        push(4, 4);
        idle_wait(50);
        chk("R7 loaded set served first (2=B)", first_rd, 2);
        chk("R7 b_reads", b_reads, 4);
        chk("R7 a_reads", a_reads, 4);
        chk("R6 swap_count", int'(swap_count), 4);
        chk("R6 eng_sel", int'(eng_sel), 0);
    endtask

    task automatic t_monitor();
        clear_obs();
        push(0, LIMIT);
        idle_wait(60);
        chk("R9 equal to limit no ovf", int'(b_ovf), 0);
        chk("R8 b_peak", int'(b_peak), LIMIT);
        push(32, 0);
        idle_wait(80);
        chk("R9 a_ovf set and held", int'(a_ovf), 1);
        chk("R8 a_peak", int'(a_peak), 32);
        chk("R9 b_ovf still clear", int'(b_ovf), 0);
        chk("R3 queue a drained", a_cnt, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        t_reset();
        t_drain_a();
        t_swap_timer();
        t_swap_done();
        t_no_split();
        t_prefer();
        t_monitor();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule